// File: doc/BRIEF.md
# Branch Condition and Target Unit

This unit resolves one branch per request for a 32-bit instruction set whose instructions sit on 4-byte boundaries. A request carries the address of the branch, a 4-bit kind code, a 24-bit displacement field, two register operands and the current carry bit. The kind code selects two things: the condition that decides whether the branch is taken, and how many low bits of the displacement field are used. The selected field is sign-extended, scaled by the instruction size and added to the branch address.

The result appears one clock after the request. It gives a taken flag and the next address: the branch target when the branch is taken, or the sequential address when it is not. It also gives a link-register write enable and the value to write, which is the sequential address. The unit only reads the carry bit and never produces a new value for it. Fetch redirection, pipeline flushing and prediction are left to the surrounding pipeline.

The data path has no control states. It is a combinational evaluation stage followed by a single result register. After reset the register is in the idle state, with valid, taken and link enable all low. Each clock edge moves it into the loaded state if `req_valid` is high, or back into the idle state if `req_valid` is low.

Top module: `brcu_branch_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released with no request, `res_valid`, `res_taken` and `res_link_we` are 0.
- R2: `res_valid` equals the value `req_valid` had at the previous rising clock edge. All other results are computed from the request captured at that same edge.
- R3: For a taken branch, `res_target` = `req_pc` + (sign-extended selected displacement << 2), computed modulo 2^32.
- R4: The kind code fixes the displacement width. Codes 0 to 7 use bits [7:0] when the code is even and bits [23:0] when it is odd. Codes 8 to 15 use bits [15:0].
- R5: Codes 0 and 1 (branch always) and codes 2 and 3 (branch and link) are always taken.
- R6: Codes 4 and 5 are taken when `req_carry` = 1. Codes 6 and 7 are taken when `req_carry` = 0.
- R7: Code 8 is taken when `req_opa` == `req_opb`. Code 9 is taken when the two operands differ.
- R8: Codes 10 to 15 compare `req_opa`, read as a signed number, against zero. In order, the tests are ==0, !=0, >=0, >0, <=0 and <0.
- R9: When the branch is not taken, `res_target` = `req_pc` + 4, computed modulo 2^32.
- R10: `res_link_we` is 1 only for codes 2 and 3, and in that case `res_link_val` = `req_pc` + 4.
- R11: Displacement bits above the selected width have no effect on `res_target`.
- R12: A cycle with `req_valid` low produces `res_taken` = 0 and `res_link_we` = 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A branch request is present |
| req_kind | input | 4 | Branch kind code (see R4 to R8) |
| req_pc | input | 32 | Address of the branch instruction |
| req_disp | input | 24 | Raw displacement field |
| req_opa | input | 32 | First register operand |
| req_opb | input | 32 | Second register operand |
| req_carry | input | 1 | Current carry bit |
| res_valid | output | 1 | Result register holds a request |
| res_taken | output | 1 | Branch is taken |
| res_target | output | 32 | Next instruction address |
| res_link_we | output | 1 | Write the link register |
| res_link_val | output | 32 | Value for the link register |

## Verification
The bench runs every kind code against a grid of operand pairs that includes zero, one, minus one, and the largest and smallest signed values. A unit that compared operands as unsigned would therefore get the >=0, >0, <=0 and <0 tests wrong on the negative extremes. Each displacement pattern is built so that its 8-bit, 16-bit and 24-bit readings differ in sign, or are padded with non-zero upper bits. A unit that chose the wrong width, zero-extended instead of sign-extending, or let the upper bits leak into the sum would produce a wrong target. A branch address near the top of the address space checks that both the taken sum and the fall-through sum wrap modulo 2^32. Link-enable checks on every code catch a link write leaking onto plain branch-always.

// File: rtl/brcu_pkg.sv
package brcu_pkg;

    typedef enum logic [3:0] {
        K_ALW8  = 4'd0,
        K_ALW24 = 4'd1,
        K_LNK8  = 4'd2,
        K_LNK24 = 4'd3,
        K_CS8   = 4'd4,
        K_CS24  = 4'd5,
        K_CC8   = 4'd6,
        K_CC24  = 4'd7,
        K_EQ    = 4'd8,
        K_NE    = 4'd9,
        K_EQZ   = 4'd10,
        K_NEZ   = 4'd11,
        K_GEZ   = 4'd12,
        K_GTZ   = 4'd13,
        K_LEZ   = 4'd14,
        K_LTZ   = 4'd15
    } br_kind_e;

    typedef enum logic [1:0] {
        DSEL_8  = 2'd0,
        DSEL_16 = 2'd1,
        DSEL_24 = 2'd2
    } disp_sel_e;

    // Width choice follows the kind code layout (R4)
    function automatic disp_sel_e kind_disp_sel(input logic [3:0] kind);
        if (kind[3])      return DSEL_16;
        else if (kind[0]) return DSEL_24;
        else              return DSEL_8;
    endfunction

endpackage

// File: rtl/brcu_disp_ext.sv
module brcu_disp_ext
    import brcu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 24,
    parameter int SHIFT  = 2
) (
    input  disp_sel_e           sel,
    input  logic [DISP_W-1:0]   disp,
    output logic [ADDR_W-1:0]   offset
);
    localparam int MID_W = 16;
    localparam int LOW_W = 8;

    logic [ADDR_W-1:0] ext;

    // Only the selected low bits take part; higher bits are dropped (R11)
    always_comb begin
        unique case (sel)
            DSEL_8:  ext = {{(ADDR_W-LOW_W){disp[LOW_W-1]}}, disp[LOW_W-1:0]};
            DSEL_16: ext = {{(ADDR_W-MID_W){disp[MID_W-1]}}, disp[MID_W-1:0]};
            default: ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
        endcase
    end

    assign offset = ext << SHIFT;

endmodule

// File: rtl/brcu_cond_eval.sv
module brcu_cond_eval
    import brcu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  br_kind_e            kind,
    input  logic [DATA_W-1:0]   opa,
    input  logic [DATA_W-1:0]   opb,
    input  logic                carry,
    output logic                take,
    output logic                link
);
    logic a_zero;
    logic a_neg;

    assign a_zero = (opa == '0);
    assign a_neg  = opa[DATA_W-1];

    always_comb begin
        take = 1'b0;
        link = 1'b0;
        unique case (kind)
            K_ALW8, K_ALW24: take = 1'b1;
            K_LNK8, K_LNK24: begin
                take = 1'b1;
                link = 1'b1;
            end
            K_CS8, K_CS24:   take = carry;
            K_CC8, K_CC24:   take = !carry;
            K_EQ:            take = (opa == opb);
            K_NE:            take = (opa != opb);
            K_EQZ:           take = a_zero;
            K_NEZ:           take = !a_zero;
            K_GEZ:           take = !a_neg;
            K_GTZ:           take = !a_neg && !a_zero;
            K_LEZ:           take = a_neg || a_zero;
            K_LTZ:           take = a_neg;
            default:         take = 1'b0;
        endcase
    end

endmodule

// File: rtl/brcu_branch_unit.sv
module brcu_branch_unit
    import brcu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 24,
    parameter int SHIFT  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [3:0]          req_kind,
    input  logic [ADDR_W-1:0]   req_pc,
    input  logic [DISP_W-1:0]   req_disp,
    input  logic [ADDR_W-1:0]   req_opa,
    input  logic [ADDR_W-1:0]   req_opb,
    input  logic                req_carry,
    output logic                res_valid,
    output logic                res_taken,
    output logic [ADDR_W-1:0]   res_target,
    output logic                res_link_we,
    output logic [ADDR_W-1:0]   res_link_val
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << SHIFT;

    br_kind_e          kind;
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] seq_pc;
    logic [ADDR_W-1:0] jump_pc;
    logic              take;
    logic              link;

    assign kind    = br_kind_e'(req_kind);
    assign seq_pc  = req_pc + STEP;
    assign jump_pc = req_pc + offset;

    brcu_disp_ext #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W),
        .SHIFT  (SHIFT)
    ) u_disp (
        .sel    (kind_disp_sel(req_kind)),
        .disp   (req_disp),
        .offset (offset)
    );

    brcu_cond_eval #(
        .DATA_W (ADDR_W)
    ) u_cond (
        .kind   (kind),
        .opa    (req_opa),
        .opb    (req_opb),
        .carry  (req_carry),
        .take   (take),
        .link   (link)
    );

    // Result register: idle after reset, loaded when a request was present
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid    <= 1'b0;
            res_taken    <= 1'b0;
            res_link_we  <= 1'b0;
            res_target   <= '0;
            res_link_val <= '0;
        end else begin
            res_valid    <= req_valid;
            res_taken    <= req_valid && take;
            res_link_we  <= req_valid && link;
            res_target   <= take ? jump_pc : seq_pc;
            res_link_val <= seq_pc;
        end
    end

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    a_r5_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind[3:2] == 2'b00) |=> res_taken);

    a_r9_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_taken) |-> res_target == $past(req_pc) + STEP);

    a_r10_link_implies_taken: assert property (@(posedge clk) disable iff (!rst_n)
        res_link_we |-> res_taken);

    a_r10_link_value: assert property (@(posedge clk) disable iff (!rst_n)
        res_link_we |-> res_link_val == $past(req_pc) + STEP);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!res_taken && !res_link_we));

endmodule

// File: tb/brcu_branch_unit_test.sv
module brcu_branch_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_kind = '0;
    logic [31:0] req_pc = '0;
    logic [23:0] req_disp = '0;
    logic [31:0] req_opa = '0;
    logic [31:0] req_opb = '0;
    logic        req_carry = 1'b0;
    logic        res_valid, res_taken, res_link_we;
    logic [31:0] res_target, res_link_val;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    brcu_branch_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_pc(req_pc), .req_disp(req_disp), .req_opa(req_opa), .req_opb(req_opb),
        .req_carry(req_carry), .res_valid(res_valid), .res_taken(res_taken),
        .res_target(res_target), .res_link_we(res_link_we), .res_link_val(res_link_val)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (kind=%0d pc=%h disp=%h a=%h b=%h c=%b)",
                     req, act, exp, req_kind, req_pc, req_disp, req_opa, req_opb, req_carry);
        end
    endtask

    function automatic logic [31:0] exp_offset(input logic [3:0] k, input logic [23:0] d);
        logic [31:0] e;
        if (k >= 4'd8)      e = {{16{d[15]}}, d[15:0]};   // R4 16-bit forms
        else if (k[0])      e = {{8{d[23]}}, d};          // R4 24-bit forms
        else                e = {{24{d[7]}}, d[7:0]};     // R4 8-bit forms
        return e << 2;
    endfunction

    function automatic logic exp_take(input logic [3:0] k, input logic [31:0] a,
                                      input logic [31:0] b, input logic c);
        case (k)
            4'd0, 4'd1, 4'd2, 4'd3: return 1'b1;          // R5
            4'd4, 4'd5:             return c;             // R6
            4'd6, 4'd7:             return !c;
            4'd8:                   return a == b;        // R7
            4'd9:                   return a != b;
            4'd10:                  return $signed(a) == 0;   // R8
            4'd11:                  return $signed(a) != 0;
            4'd12:                  return $signed(a) >= 0;
            4'd13:                  return $signed(a) > 0;
            4'd14:                  return $signed(a) <= 0;
            default:                return $signed(a) < 0;
        endcase
    endfunction

    function automatic string take_tag(input logic [3:0] k);
        if (k < 4'd4)      return "R5";
        else if (k < 4'd8) return "R6";
        else if (k < 4'd10) return "R7";
        else               return "R8";
    endfunction

    task automatic apply(input logic v, input logic [3:0] k, input logic [31:0] pc,
                         input logic [23:0] d, input logic [31:0] a, input logic [31:0] b,
                         input logic c);
        logic t;
        req_valid = v; req_kind = k; req_pc = pc; req_disp = d;
        req_opa = a; req_opb = b; req_carry = c;
        t = exp_take(k, a, b, c);
        @(posedge clk);
        @(negedge clk);
        chk("R2 valid", {31'd0, res_valid}, {31'd0, v});
        if (v) begin
            chk(take_tag(k), {31'd0, res_taken}, {31'd0, t});
            if (t) chk("R3,R4,R11 target", res_target, pc + exp_offset(k, d));
            else   chk("R9 fallthrough", res_target, pc + 32'd4);
            chk("R10 link_we", {31'd0, res_link_we}, {31'd0, (k == 4'd2 || k == 4'd3)});
            if (k == 4'd2 || k == 4'd3) chk("R10 link value", res_link_val, pc + 32'd4);
        end else begin
            chk("R12 taken idle", {31'd0, res_taken}, 32'd0);
            chk("R12 link idle", {31'd0, res_link_we}, 32'd0);
        end
    endtask

    initial begin
        #(20 * 150000);
        total++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] ops [6];
        logic [23:0] disps [4];
        ops[0] = 32'h0000_0000; ops[1] = 32'h0000_0001; ops[2] = 32'hFFFF_FFFF;
        ops[3] = 32'h7FFF_FFFF; ops[4] = 32'h8000_0000; ops[5] = 32'h0000_0005;
        disps[0] = 24'h000001; disps[1] = 24'hFFFFFF;
        disps[2] = 24'h800080;   // 8-bit neg, 16-bit pos, 24-bit neg
        disps[3] = 24'h017FFF;   // 8-bit -1, 16-bit max pos, upper bits set
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 valid", {31'd0, res_valid}, 32'd0);
        chk("R1 taken", {31'd0, res_taken}, 32'd0);
        chk("R1 link_we", {31'd0, res_link_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after release", {31'd0, res_valid}, 32'd0);
        chk("R1 taken after release", {31'd0, res_taken}, 32'd0);
        for (int k = 0; k < 16; k++) begin
            for (int i = 0; i < 6; i++) begin
                for (int j = 0; j < 6; j++) begin
                    for (int c = 0; c < 2; c++) begin
                        for (int d = 0; d < 4; d++) begin
                            apply(1'b1, 4'(k), ((c ^ k) & 1) ? 32'hFFFF_FFFC : 32'h0040_1000,
                                  disps[d], ops[i], ops[j], 1'(c));
                        end
                    end
                end
                // R12 idle cycle with otherwise-taking inputs
                apply(1'b0, 4'(k), 32'h0000_2000, disps[i % 4], ops[i], ops[i], 1'b1);
            end
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule